// File: doc/BRIEF.md
# AHB-Lite Checking Slave Front End

This block sits between an AHB-Lite bus and a simple storage backend. It decides when the slave has taken an address phase and follows incrementing bursts beat by beat. It then produces the ready and response signals that the bus expects. The backend sees one qualified request per data phase and answers through two wires. One asks for wait states. The other flags an access that the backend cannot serve.

The block screens sequential beats for illegal traffic. A beat is illegal when no burst is open, when its transfer size differs from the size of the burst's opening beat, or when its address is not the previous beat's address plus the size step. A beat is also illegal when it crosses a 1 KB address boundary. Illegal beats and backend-flagged accesses get the two-cycle error response, and the backend is never asked to commit them. After an error the burst tracker closes, so the master must start again with a non-sequential transfer.

Transfer encodings are IDLE=00, BUSY=01, NONSEQ=10 and SEQ=11. The size step is 2^hsize bytes.

Top module: `ahbl_resp_front`

## Requirements
- R1: After reset, and in any cycle with no data phase in progress, hreadyout is 1 and hresp is 00 (OKAY).
- R2: An address phase is taken only in a cycle where hsel, htrans[1] and hready are all 1. After an IDLE (00) or BUSY (01) transfer, or an unselected cycle, be_req stays 0 in the next cycle.
- R3: A legal transfer taken in cycle N drives be_req=1 in cycle N+1, with be_addr, be_write and be_size equal to the sampled haddr, hwrite and hsize. With be_wait=0 that cycle shows hreadyout=1 and hresp=00.
- R4: While be_wait=1 during a legal data phase, hreadyout is 0 and hresp is 00 (OKAY). be_we is asserted only in the cycle that completes a write, which is the cycle where be_wait=0 and be_unsup=0.
- R5: Every error is two cycles long. The first cycle has hresp=01 (ERROR) with hreadyout=0. The next cycle has hresp=01 with hreadyout=1.
- R6: A SEQ (11) beat whose hsize differs from the hsize of the burst's NONSEQ (10) beat gets the error response.
- R7: A SEQ beat whose address is not the previous beat's address plus 2^hsize gets the error response.
- R8: A SEQ beat that lands in a different 1 KB region (haddr[AW-1:10]) from the previous beat gets the error response, even when its address is the correct increment.
- R9: A SEQ beat gets the error response when no burst is open. A burst is closed by an IDLE or unselected cycle with hready=1, and by any error. A BUSY cycle keeps it open.
- R10: If the backend raises be_unsup in a data phase with be_wait=0, that beat gets the error response and be_we stays 0. A beat rejected by the protocol checks never raises be_req.
- R11: hresp only takes the values 00 and 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | AW | Address-phase address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Address-phase write flag |
| hsize | input | 3 | Transfer size, log2 of bytes |
| hready | input | 1 | Bus-wide ready from the response mux |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 2 | Response, 00 OKAY or 01 ERROR |
| be_req | output | 1 | Legal data phase presented to the backend |
| be_write | output | 1 | Data phase is a write |
| be_addr | output | AW | Data-phase address |
| be_size | output | 3 | Data-phase size |
| be_wait | input | 1 | Backend asks for a wait state |
| be_unsup | input | 1 | Backend rejects the access |
| be_we | output | 1 | Write commit strobe |

## Verification
An address phase sampled at one rising edge shows its effect from the next cycle onward: be_req, the address fields, ready and any first error cycle all appear there. The second error cycle follows exactly one cycle after the first. Backend wait and unsupported inputs act combinationally within the same data-phase cycle. The bench drives each cycle just after the rising edge and samples every output at the falling edge. There it compares against a behavioural model that is advanced only at the rising edge, so each result is checked in the cycle it is due.

// File: rtl/ahbl_resp_front.sv
module ahbl_resp_front #(
  parameter int AW       = 32,
  parameter int BOUND_LG = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel,
  input  logic [AW-1:0] haddr,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [2:0]    hsize,
  input  logic          hready,
  output logic          hreadyout,
  output logic [1:0]    hresp,
  output logic          be_req,
  output logic          be_write,
  output logic [AW-1:0] be_addr,
  output logic [2:0]    be_size,
  input  logic          be_wait,
  input  logic          be_unsup,
  output logic          be_we
);
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;
  localparam logic [1:0] RSP_OK  = 2'b00;
  localparam logic [1:0] RSP_ERR = 2'b01;

  logic          dp_q, bad_q, err2_q, wr_q, burst_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    size_q, bsize_q;
  logic [AW-1:0] step, next_addr;
  logic          accept, seq_bad, in_dp, first_err, stall;

  assign accept    = hsel & htrans[1] & hready;
  assign step      = {{(AW-1){1'b0}}, 1'b1} << bsize_q;
  assign next_addr = addr_q + step;
  assign seq_bad   = ~burst_q | (hsize != bsize_q) | (haddr != next_addr)
                   | (haddr[AW-1:BOUND_LG] != addr_q[AW-1:BOUND_LG]);

  assign in_dp     = dp_q & ~err2_q;
  assign first_err = in_dp & (bad_q | (~be_wait & be_unsup));
  assign stall     = in_dp & ~bad_q & be_wait;

  assign hreadyout = ~(stall | first_err);
  assign hresp     = (first_err | err2_q) ? RSP_ERR : RSP_OK;
  assign be_req    = in_dp & ~bad_q;
  assign be_write  = wr_q;
  assign be_addr   = addr_q;
  assign be_size   = size_q;
  assign be_we     = be_req & wr_q & ~be_wait & ~be_unsup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q    <= 1'b0;
      bad_q   <= 1'b0;
      err2_q  <= 1'b0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      bsize_q <= '0;
    end else begin
      err2_q <= first_err;
      if (hready) begin
        dp_q <= accept;
        if (accept) begin
          addr_q <= haddr;
          wr_q   <= hwrite;
          size_q <= hsize;
          bad_q  <= (htrans == TR_SEQ) & seq_bad;
          if (htrans == TR_NSEQ) begin
            burst_q <= 1'b1;
            bsize_q <= hsize;
          end
        end else if (!(hsel && htrans == TR_BUSY)) begin
          burst_q <= 1'b0;
        end
      end
      if (first_err) burst_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ahbl_resp_front_chk.sv
module ahbl_resp_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hsel,
  input logic [1:0] htrans,
  input logic       hready,
  input logic       hreadyout,
  input logic [1:0] hresp,
  input logic       be_req,
  input logic       be_wait,
  input logic       be_unsup,
  input logic       be_we
);
  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!be_req && hresp == 2'b00) |-> hreadyout);

  assert_no_spurious_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && !(hsel && htrans[1])) |=> !be_req);

  assert_nonseq_reaches_backend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && hreadyout && hsel && htrans == 2'b10) |=> be_req);

  assert_wait_stalls_okay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && be_wait) |-> (!hreadyout && hresp == 2'b00));

  assert_err_first_then_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp == 2'b01 && !hreadyout) |=> (hresp == 2'b01 && hreadyout));

  assert_err_second_has_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp == 2'b01 && hreadyout) |-> $past(hresp == 2'b01 && !hreadyout));

  assert_commit_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    be_we |-> (!be_unsup && hreadyout && hresp == 2'b00));

  assert_lite_codes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hresp[1]);
endmodule

bind ahbl_resp_front ahbl_resp_front_chk i_chk (
  .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hready(hready),
  .hreadyout(hreadyout), .hresp(hresp), .be_req(be_req), .be_wait(be_wait),
  .be_unsup(be_unsup), .be_we(be_we)
);

// File: tb/test_ahbl_resp_front.sv
module test_ahbl_resp_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'd2;
  logic        hready;
  logic        hreadyout;
  logic [1:0]  hresp;
  logic        be_req, be_write, be_we;
  logic [31:0] be_addr;
  logic [2:0]  be_size;
  logic        be_wait = 1'b0;
  logic        be_unsup = 1'b0;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  assign hready = hreadyout;

  always #2.5 clk = ~clk;

  ahbl_resp_front #(.AW(32), .BOUND_LG(10)) i_ahbl_resp_front (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hready(hready), .hreadyout(hreadyout),
    .hresp(hresp), .be_req(be_req), .be_write(be_write), .be_addr(be_addr),
    .be_size(be_size), .be_wait(be_wait), .be_unsup(be_unsup), .be_we(be_we)
  );

  // behavioural reference state
  bit          m_dp, m_bad, m_err2, m_wr, m_open;
  int unsigned m_addr;
  int          m_size, m_bsize;
  bit          e_ready, e_req, e_we, e_fe;
  int          e_resp;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      tag = "R1";
      chk("hreadyout in reset", hreadyout, 1);
      chk("hresp in reset", hresp, 0);
      chk("be_req in reset", be_req, 0);
    end else begin
      bit live;
      live   = m_dp && !m_err2;
      e_fe   = live && (m_bad || (!be_wait && be_unsup));
      e_ready = !((live && !m_bad && be_wait) || e_fe);
      e_resp = (e_fe || m_err2) ? 1 : 0;
      e_req  = live && !m_bad;
      e_we   = e_req && m_wr && !be_wait && !be_unsup;
      chk("hreadyout", hreadyout, e_ready);
      chk("hresp", hresp, e_resp);
      chk("be_req", be_req, e_req);
      chk("be_we", be_we, e_we);
      if (e_req) begin
        chk("be_addr", be_addr, m_addr);
        chk("be_write", be_write, m_wr);
        chk("be_size", be_size, m_size);
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dp = 0; m_bad = 0; m_err2 = 0; m_wr = 0; m_open = 0;
      m_addr = 0; m_size = 0; m_bsize = 0;
    end else begin
      bit taken, nb;
      if (e_ready) begin
        taken = hsel && htrans[1];
        if (taken) begin
          nb = 0;
          if (htrans == 2'b11)
            nb = !m_open || (int'(hsize) != m_bsize)
               || (haddr != m_addr + (32'd1 << m_bsize))
               || ((haddr >> 10) != (m_addr >> 10));
          if (htrans == 2'b10) begin
            m_open = 1; m_bsize = int'(hsize);
          end
          m_bad = nb; m_addr = haddr; m_wr = hwrite; m_size = int'(hsize);
        end else if (!(hsel && htrans == 2'b01)) begin
          m_open = 0;
        end
        m_dp = taken;
      end
      if (e_fe) m_open = 0;
      m_err2 = e_fe;
    end
  end

  task automatic cyc(bit s, logic [1:0] t, bit w, int sz, int unsigned a,
                     bit wt, bit un);
    hsel = s; htrans = t; hwrite = w; hsize = 3'(sz); haddr = a;
    be_wait = wt; be_unsup = un;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 2'b00, 0, 2, 0, 0, 0);
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    tag = "R2";
    cyc(0, 2'b10, 1, 2, 32'h40, 0, 0);
    cyc(1, 2'b00, 1, 2, 32'h40, 0, 0);
    cyc(1, 2'b01, 1, 2, 32'h40, 0, 0);
    idle(2);

    tag = "R3";
    cyc(1, 2'b10, 1, 2, 32'h100, 0, 0);
    cyc(1, 2'b11, 1, 2, 32'h104, 0, 0);
    cyc(1, 2'b11, 1, 2, 32'h108, 0, 0);
    cyc(1, 2'b10, 0, 0, 32'h133, 0, 0);
    idle(2);

    tag = "R4";
    cyc(1, 2'b10, 0, 2, 32'h200, 0, 0);
    cyc(1, 2'b10, 1, 1, 32'h210, 1, 0);
    cyc(1, 2'b10, 1, 1, 32'h210, 1, 0);
    cyc(1, 2'b10, 1, 1, 32'h210, 0, 0);
    cyc(0, 2'b00, 0, 2, 0, 1, 0);
    cyc(0, 2'b00, 0, 2, 0, 0, 0);
    idle(2);

    tag = "R6";
    cyc(1, 2'b10, 0, 2, 32'h300, 0, 0);
    cyc(1, 2'b11, 0, 1, 32'h304, 0, 0);
    idle(4);

    tag = "R7";
    cyc(1, 2'b10, 1, 2, 32'h400, 0, 0);
    cyc(1, 2'b11, 1, 2, 32'h40C, 0, 0);
    idle(4);

    tag = "R8";
    cyc(1, 2'b10, 0, 2, 32'h7F8, 0, 0);
    cyc(1, 2'b11, 0, 2, 32'h7FC, 0, 0);
    cyc(1, 2'b11, 0, 2, 32'h800, 0, 0);
    idle(4);

    tag = "R9";
    cyc(1, 2'b11, 0, 2, 32'h504, 0, 0);
    idle(3);
    cyc(1, 2'b10, 0, 2, 32'hA00, 0, 0);
    cyc(1, 2'b01, 0, 2, 32'hA04, 0, 0);
    cyc(1, 2'b11, 0, 2, 32'hA04, 0, 0);
    cyc(1, 2'b00, 0, 2, 32'hA08, 0, 0);
    cyc(1, 2'b11, 0, 2, 32'hA08, 0, 0);
    idle(4);

    tag = "R10";
    cyc(1, 2'b10, 1, 2, 32'h600, 0, 0);
    cyc(0, 2'b00, 0, 2, 0, 0, 1);
    cyc(0, 2'b00, 0, 2, 0, 0, 0);
    cyc(1, 2'b10, 1, 2, 32'h610, 0, 0);
    cyc(0, 2'b00, 0, 2, 0, 1, 1);
    cyc(0, 2'b00, 0, 2, 0, 0, 1);
    cyc(0, 2'b00, 0, 2, 0, 0, 0);
    idle(2);

    tag = "R5";
    cyc(1, 2'b10, 0, 2, 32'h800, 0, 0);
    cyc(1, 2'b11, 0, 2, 32'h808, 0, 0);
    cyc(1, 2'b10, 0, 2, 32'h900, 0, 0);
    cyc(1, 2'b10, 0, 2, 32'h900, 0, 0);
    cyc(1, 2'b11, 0, 2, 32'h904, 0, 0);
    idle(3);

    tag = "R11";
    cyc(1, 2'b11, 1, 3, 32'hC08, 0, 0);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule